// File: doc/BRIEF.md
# USB Interrupt Status Register Bank

This block holds the interrupt flags of a USB device controller together with their enables. Single-cycle event pulses from the serial interface engine set sticky flags. Software reads the flags over a small register bus and clears them by writing 0, or sets them by writing 1 when debugging. All enabled flags are ORed into one interrupt line.

The error flag cannot be written. It is derived from an external error-status byte, qualified by a software error mask. A bus-reset event also zeroes the device-address register.

Transaction results are queued in a four-entry status FIFO, whose oldest entry is visible on an output port. Clearing the transaction-complete flag retires that entry. If more entries remain, the flag comes back one cycle later, so each completed transaction is reported by its own flag cycle.

Top module: `usb_irq_regs`

## Requirements
- R1: The register map uses `addr_i` as follows: 0 is status, 1 is enable, 2 is error mask, 3 is device address. Status bit 7 always reads 0. Status bits 6 down to 0 are start-of-frame, stall, idle, transaction-complete, bus activity, error and bus reset.
- R2: An event pulse sets its status flag at the next clock edge. The flag stays set through later cycles until software writes 0 to that bit at address 0.
- R3: A status write at address 0 loads each writable bit from `wdata_i`, so a 1 sets a flag and a 0 clears it. When a hardware event and a clearing write hit the same flag in the same cycle, the flag is set.
- R4: `irq_o` is 1 exactly when at least one status bit 6..0 is 1 and its enable bit is also 1. The enable register holds bits 6..0, and its bit 7 reads 0.
- R5: Status bit 1 equals the OR of (`err_stat_i` AND the error-mask register). Writes to status bit 1 have no effect.
- R6: A bus-reset pulse sets status bit 0. At the same edge it clears the 7-bit device-address register (address 3, bit 7 reads 0), and this wins over a write to address 3 in that cycle.
- R7: `txn_push_i` stores `txn_stat_i` in a 4-entry FIFO. `txn_head_o` shows the oldest entry, or 0 when the FIFO is empty. A push into an empty FIFO sets status bit 3 at the next edge.
- R8: Writing 0 to status bit 3 while bit 3 is 1 and the FIFO is not empty removes one entry. Bit 3 then reads 0 for one cycle. If entries remain, it reads 1 again on the following cycle.
- R9: A push into a full FIFO with no pop in the same cycle is dropped, and `txn_ovf_o` is 1 in that cycle. A push together with a pop into a full FIFO is accepted.
- R10: An active-low reset clears all flags, the enable, mask and address registers, and the FIFO to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_evt_i | input | 1 | Start-of-frame received pulse |
| stall_evt_i | input | 1 | Stall handshake sent pulse |
| idle_evt_i | input | 1 | Qualified idle-detected pulse |
| actv_evt_i | input | 1 | Bus activity pulse |
| busrst_evt_i | input | 1 | Bus reset pulse |
| err_stat_i | input | 8 | Error-status byte from the engine |
| txn_push_i | input | 1 | Transaction done, push status entry |
| txn_stat_i | input | 8 | Transaction status entry |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Combinational read data |
| irq_o | output | 1 | Combined interrupt |
| txn_head_o | output | 8 | Oldest FIFO entry, 0 when empty |
| txn_ovf_o | output | 1 | Push dropped because the FIFO is full |
| dev_addr_o | output | 7 | Device address |

## Verification
The flags are first driven one event at a time, then all at once, then with a clearing write landing on the same edge as a set. These cases separate the sticky-set behaviour from the write-loads-bit behaviour and from the set-wins rule.

The FIFO is filled past capacity, drained one pop at a time, and hit with a simultaneous pop and push while full. This tells a dropped push from an accepted one and exposes the one-cycle gap in the transaction flag. A long stretch of random events, pushes and writes to random addresses then mixes every path, including bus reset against an address write and the error mask against changing error bytes.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_DW = 8;
  localparam int NFLAG  = 7;
  localparam int ADDR_W = 7;

  localparam int B_SOF   = 6;
  localparam int B_STALL = 5;
  localparam int B_IDLE  = 4;
  localparam int B_TRN   = 3;
  localparam int B_ACTV  = 2;
  localparam int B_ERR   = 1;
  localparam int B_RST   = 0;

  typedef enum logic [1:0] {
    A_STAT  = 2'd0,
    A_EN    = 2'd1,
    A_EMASK = 2'd2,
    A_DADDR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
  import usb_irq_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    if (b == B_ERR) begin : g_ro
      // read-only level, driven from the error mask logic
      logic unused_wr;
      assign unused_wr = wdata_i[b] ^ wr_i;
      assign flag_o[b] = hw_set_i[b];
    end else begin : g_rw
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= hw_set_i[b] | (wr_i ? wdata_i[b] : q);
      end
      assign flag_o[b] = q;
    end
  end
endmodule

// File: rtl/usb_irq_txn_fifo.sv
module usb_irq_txn_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          acc_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          empty, full, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign pop_ok = pop_i & ~empty;
  assign acc_o  = push_i & (~full | pop_ok);
  assign ovf_o  = push_i & full & ~pop_ok;
  assign head_o = empty ? '0 : mem_q[rd_q];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (acc_o) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (pop_ok) rd_q <= ptr_inc(rd_q);
      if (acc_o && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (!acc_o && pop_ok) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
#(
  parameter int TXN_W     = 8,
  parameter int TXN_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_evt_i,
  input  logic              stall_evt_i,
  input  logic              idle_evt_i,
  input  logic              actv_evt_i,
  input  logic              busrst_evt_i,
  input  logic [REG_DW-1:0] err_stat_i,
  input  logic              txn_push_i,
  input  logic [TXN_W-1:0]  txn_stat_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o,
  output logic [TXN_W-1:0]  txn_head_o,
  output logic              txn_ovf_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  localparam int CW = $clog2(TXN_DEPTH + 1);

  logic [NFLAG-1:0]  flags_w, hw_set;
  logic [NFLAG-1:0]  en_q;
  logic [REG_DW-1:0] emask_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [CW-1:0]     txn_cnt;
  logic              txn_acc, txn_pop, rearm_q, trn_hw, err_lvl;
  logic              stat_wr, en_wr, emask_wr, daddr_wr;

  assign stat_wr  = wr_en_i && (addr_i == A_STAT);
  assign en_wr    = wr_en_i && (addr_i == A_EN);
  assign emask_wr = wr_en_i && (addr_i == A_EMASK);
  assign daddr_wr = wr_en_i && (addr_i == A_DADDR);

  assign err_lvl = |(err_stat_i & emask_q);

  // clearing a pending transaction flag retires the head entry
  assign txn_pop = stat_wr && !wdata_i[B_TRN] && flags_w[B_TRN] && (txn_cnt != '0);
  assign trn_hw  = rearm_q | (txn_acc && (txn_cnt == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rearm_q <= 1'b0;
    else         rearm_q <= txn_pop && ((txn_cnt > CW'(1)) || txn_acc);
  end

  always_comb begin
    hw_set          = '0;
    hw_set[B_SOF]   = sof_evt_i;
    hw_set[B_STALL] = stall_evt_i;
    hw_set[B_IDLE]  = idle_evt_i;
    hw_set[B_TRN]   = trn_hw;
    hw_set[B_ACTV]  = actv_evt_i;
    hw_set[B_ERR]   = err_lvl;
    hw_set[B_RST]   = busrst_evt_i;
  end

  usb_irq_flags #(.N(NFLAG)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_set_i (hw_set),
    .wr_i     (stat_wr),
    .wdata_i  (wdata_i[NFLAG-1:0]),
    .flag_o   (flags_w)
  );

  usb_irq_txn_fifo #(.W(TXN_W), .DEPTH(TXN_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (txn_push_i),
    .data_i (txn_stat_i),
    .pop_i  (txn_pop),
    .head_o (txn_head_o),
    .cnt_o  (txn_cnt),
    .acc_o  (txn_acc),
    .ovf_o  (txn_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      emask_q <= '0;
      daddr_q <= '0;
    end else begin
      if (en_wr)    en_q    <= wdata_i[NFLAG-1:0];
      if (emask_wr) emask_q <= wdata_i;
      if (busrst_evt_i) daddr_q <= '0;
      else if (daddr_wr) daddr_q <= wdata_i[ADDR_W-1:0];
    end
  end

  assign irq_o      = |(flags_w & en_q);
  assign dev_addr_o = daddr_q;

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = REG_DW'(flags_w);
      A_EN:    rdata_o = REG_DW'(en_q);
      A_EMASK: rdata_o = emask_q;
      default: rdata_o = REG_DW'(daddr_q);
    endcase
  end
endmodule

// File: rtl/usb_irq_regs_chk.sv
module usb_irq_regs_chk #(
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sof_evt_i,
  input logic          busrst_evt_i,
  input logic          wr_en_i,
  input logic [1:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic [6:0]    flags,
  input logic [6:0]    en_q,
  input logic          irq_o,
  input logic [6:0]    dev_addr_o,
  input logic          txn_ovf_o,
  input logic [CW-1:0] txn_cnt,
  input logic          txn_pop
);
  AST_SOF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_evt_i |=> flags[6]); // R2

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_evt_i && wr_en_i && addr_i == 2'd0 && !wdata_i[6]) |=> flags[6]); // R3

  AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_evt_i && wr_en_i && addr_i == 2'd0 && !wdata_i[6]) |=> !flags[6]); // R3

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 7'd0) |-> !irq_o); // R4

  AST_ADDR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busrst_evt_i |=> (dev_addr_o == 7'd0 && flags[0])); // R6

  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_pop && txn_cnt > CW'(1)) |=> !flags[3] ##1 flags[3]); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_ovf_o |=> $stable(txn_cnt)); // R9
endmodule

bind usb_irq_regs usb_irq_regs_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sof_evt_i    (sof_evt_i),
  .busrst_evt_i (busrst_evt_i),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .flags        (flags_w),
  .en_q         (en_q),
  .irq_o        (irq_o),
  .dev_addr_o   (dev_addr_o),
  .txn_ovf_o    (txn_ovf_o),
  .txn_cnt      (txn_cnt),
  .txn_pop      (txn_pop)
);

// File: tb/sim_usb_irq_regs.sv
module sim_usb_irq_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 0, stall = 0, idle = 0, actv = 0, busrst = 0;
  logic [7:0] err_stat = 0;
  logic       push = 0;
  logic [7:0] stat = 0;
  logic       we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic       irq, ovf;
  logic [7:0] head;
  logic [6:0] daddr;

  int    n_tot = 0, n_fail = 0;
  string tag = "R10";

  bit [6:0] m_flag = 0, m_en = 0;
  bit [7:0] m_mask = 0;
  bit [6:0] m_addr = 0;
  bit       m_rearm = 0;
  bit [7:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_regs u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sof_evt_i(sof), .stall_evt_i(stall), .idle_evt_i(idle),
    .actv_evt_i(actv), .busrst_evt_i(busrst),
    .err_stat_i(err_stat), .txn_push_i(push), .txn_stat_i(stat),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .irq_o(irq), .txn_head_o(head),
    .txn_ovf_o(ovf), .dev_addr_o(daddr)
  );

  task automatic check_eq(input string t, input string what, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h @%0t", t, what, act, exp, $time);
    end
  endtask

  function automatic bit [6:0] m_status();
    bit [6:0] s = m_flag;
    s[1] = |(err_stat & m_mask);
    return s;
  endfunction

  function automatic bit [7:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return {1'b0, m_status()};
      2'd1: return {1'b0, m_en};
      2'd2: return m_mask;
      default: return {1'b0, m_addr};
    endcase
  endfunction

  function automatic bit m_pop();
    return we && addr == 2'd0 && !wd[3] && m_flag[3] && q.size() > 0;
  endfunction

  task automatic model_step();
    bit wr0 = we && addr == 2'd0;
    int n = q.size();
    bit pop = m_pop();
    bit acc = push && (n < 4 || pop);
    bit trn_hw = m_rearm || (acc && n == 0);
    bit [6:0] nf;
    m_rearm = pop && (n - 1 + int'(acc)) > 0;
    if (pop) void'(q.pop_front());
    if (acc) q.push_back(stat);
    nf[6] = sof    | (wr0 ? wd[6] : m_flag[6]);
    nf[5] = stall  | (wr0 ? wd[5] : m_flag[5]);
    nf[4] = idle   | (wr0 ? wd[4] : m_flag[4]);
    nf[3] = trn_hw | (wr0 ? wd[3] : m_flag[3]);
    nf[2] = actv   | (wr0 ? wd[2] : m_flag[2]);
    nf[1] = 1'b0;
    nf[0] = busrst | (wr0 ? wd[0] : m_flag[0]);
    m_flag = nf;
    if (we && addr == 2'd1) m_en = wd[6:0];
    if (we && addr == 2'd2) m_mask = wd;
    if (busrst) m_addr = 0;
    else if (we && addr == 2'd3) m_addr = wd[6:0];
  endtask

  // compare all outputs, take one edge, update model, release pulses
  task automatic tick();
    #1;
    check_eq(tag, "rdata", rdata, m_read(addr));
    check_eq("R4", "irq", irq, |(m_status() & m_en));
    check_eq("R7", "head", head, q.size() > 0 ? q[0] : 0);
    check_eq("R9", "ovf", ovf, push && q.size() == 4 && !m_pop());
    check_eq("R6", "dev_addr", daddr, m_addr);
    @(posedge clk);
    model_step();
    @(negedge clk);
    sof = 0; stall = 0; idle = 0; actv = 0; busrst = 0;
    push = 0; we = 0;
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    we = 1; addr = a; wd = d; tick();
  endtask

  task automatic rd_chk(input bit [1:0] a, input string t, input int exp);
    addr = a; #1;
    check_eq(t, "read", rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tot++; n_fail++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd_chk(2'(a), "R10", 0);
      tick();
    end
    check_eq("R10", "irq", irq, 0);

    // R2 single event sets and sticks
    tag = "R2";
    sof = 1; tick();
    rd_chk(0, "R2", 8'h40);
    tick(); tick();
    rd_chk(0, "R2", 8'h40);

    // R1 all events, bit map and bit 7
    tag = "R1";
    stall = 1; idle = 1; actv = 1; busrst = 1; tick();
    rd_chk(0, "R1", 8'h75);

    // R3 write 0 clears, write 1 sets, set wins
    tag = "R3";
    wr(0, 8'h00);
    rd_chk(0, "R3", 8'h00);
    wr(0, 8'hFF);
    rd_chk(0, "R3", 8'h7D);
    sof = 1; wr(0, 8'h00);
    rd_chk(0, "R3", 8'h40);

    // R4 enable gating
    tag = "R4";
    #1; check_eq("R4", "irq_noen", irq, 0);
    wr(1, 8'h20);
    #1; check_eq("R4", "irq_other", irq, 0);
    wr(1, 8'hC0);
    rd_chk(1, "R4", 8'h40);
    #1; check_eq("R4", "irq_on", irq, 1);

    // R5 masked error, read-only
    tag = "R5";
    wr(0, 8'h00);
    wr(2, 8'h0F);
    err_stat = 8'h10;
    rd_chk(0, "R5", 8'h00);
    wr(0, 8'h02);
    rd_chk(0, "R5", 8'h00);
    err_stat = 8'h01;
    rd_chk(0, "R5", 8'h02);
    wr(0, 8'h00);
    rd_chk(0, "R5", 8'h02);
    err_stat = 8'h00;
    tick();

    // R6 bus reset beats address write
    tag = "R6";
    wr(3, 8'hAA);
    rd_chk(3, "R6", 8'h2A);
    busrst = 1; wr(3, 8'h55);
    #1; check_eq("R6", "daddr", daddr, 0);
    rd_chk(0, "R6", 8'h01);

    // R7 R8 R9 FIFO
    tag = "R7";
    wr(0, 8'h00);
    stat = 8'hA1; push = 1; tick();
    rd_chk(0, "R7", 8'h08);
    #1; check_eq("R7", "head", head, 8'hA1);
    foreach (q[i]) ;
    stat = 8'hB2; push = 1; tick();
    stat = 8'hC3; push = 1; tick();
    stat = 8'hD4; push = 1; tick();
    stat = 8'hE5; push = 1;
    #1; check_eq("R9", "ovf_full", ovf, 1);
    tick();
    tag = "R8";
    wr(0, 8'h00);
    rd_chk(0, "R8", 8'h00);
    #1; check_eq("R8", "head_pop", head, 8'hB2);
    addr = 0; tick();
    rd_chk(0, "R8", 8'h08);
    stat = 8'hF6; push = 1; tick();
    tag = "R9";
    stat = 8'h17; push = 1; we = 1; addr = 0; wd = 8'h00;
    #1; check_eq("R9", "ovf_poppush", ovf, 0);
    tick();
    tag = "R8";
    for (int k = 0; k < 4; k++) begin
      addr = 0; tick();
      wr(0, 8'h00);
    end
    rd_chk(0, "R8", 8'h00);
    addr = 0; tick(); tick();
    rd_chk(0, "R8", 8'h00);
    #1; check_eq("R7", "head_empty", head, 0);

    // mixed random traffic
    tag = "R2";
    for (int c = 0; c < 600; c++) begin
      sof    = ($urandom % 8) == 0;
      stall  = ($urandom % 10) == 0;
      idle   = ($urandom % 12) == 0;
      actv   = ($urandom % 6) == 0;
      busrst = ($urandom % 40) == 0;
      push   = ($urandom % 3) == 0;
      stat   = 8'($urandom);
      if (($urandom % 16) == 0) err_stat = 8'($urandom);
      we     = ($urandom % 4) == 0;
      addr   = 2'($urandom);
      wd     = 8'($urandom);
      if (we && addr == 2'd0 && ($urandom % 2) == 0) wd[3] = 1'b0;
      tick();
    end

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule